// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the integer register storage of a 32-bit processor, built as several complete banks of thirty-two registers each. The bank used by ordinary instruction traffic is chosen at run time by a current-set index, which normally comes from a field of the status control register. Switching context then only means changing that index: no registers have to be saved to memory or loaded back.

A second, cross-bank path reaches a different bank, chosen by a previous-set index. Privileged code uses it to read a value from another bank, or to write one into it, while the current bank stays selected. The number of extra banks beyond the normal one is a build-time parameter from 0 to 63. A small control-register bank sits beside the integer banks. Only supervisor mode may write it; a user-mode write is dropped and flagged.

All read data is registered, so it appears one clock after the address. The integer banks are kept in memories that can map to block RAM.

Top module: `banked_regfile`

## Requirements
- R1: The block holds NUM_SHADOW+1 independent banks, each of 32 registers of 32 bits. A value written to register r of one bank appears in no other bank.
- R2: Ports A and B read register ra_addr and register rb_addr of the bank given by cur_set. The data appears on ra_data and rb_data after the next rising clock edge.
- R3: When wr_en is 1, wr_data is written at the clock edge into register wr_addr of the bank given by cur_set, and into no other bank.
- R4: In every bank, register 0 reads as zero on every read port, including the cross path. A write to register 0 through either write path is discarded.
- R5: The cross path reads register xr_addr of the bank given by prev_set. The data appears on xr_data after the next rising clock edge.
- R6: When xw_en is 1, xw_data is written into register xw_addr of the bank given by prev_set. If wr_en and xw_en are both 1 in the same cycle, only the normal write takes place and the cross write is dropped.
- R7: A read issued in the same cycle as a write to the same register returns the value held before that write.
- R8: A cur_set or prev_set value greater than NUM_SHADOW selects bank 0, for reads and for writes.
- R9: The control bank holds NUM_CTRL registers of 32 bits. When super_mode is 1, cr_wr_en writes cr_wr_data into register cr_wr_addr. Reads on cr_rd_addr appear after one clock edge. Addresses at or above NUM_CTRL read as zero and ignore writes.
- R10: A control write with super_mode 0 leaves every control register unchanged. priv_fault is 1 in the cycle after such a write and 0 after any cycle without one.
- R11: Synchronous reset clears every integer register of every bank, every control register, all read outputs and priv_fault to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_set | input | 6 | Index of the active bank |
| prev_set | input | 6 | Index of the bank reached by the cross path |
| super_mode | input | 1 | 1 = supervisor, 0 = user |
| ra_addr | input | 5 | Read port A register number |
| ra_data | output | 32 | Read port A data (registered) |
| rb_addr | input | 5 | Read port B register number |
| rb_data | output | 32 | Read port B data (registered) |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 5 | Normal write register number |
| wr_data | input | 32 | Normal write data |
| xr_addr | input | 5 | Cross-bank read register number |
| xr_data | output | 32 | Cross-bank read data (registered) |
| xw_en | input | 1 | Cross-bank write enable |
| xw_addr | input | 5 | Cross-bank write register number |
| xw_data | input | 32 | Cross-bank write data |
| cr_rd_addr | input | 5 | Control register read address |
| cr_rd_data | output | 32 | Control register read data (registered) |
| cr_wr_en | input | 1 | Control register write enable |
| cr_wr_addr | input | 5 | Control register write address |
| cr_wr_data | input | 32 | Control register write data |
| priv_fault | output | 1 | One-cycle flag for a user-mode control write |

## Verification
The assertions check four behaviours on every cycle: register 0 reads as zero on both normal ports and the cross port, priv_fault follows a user-mode control write and stays low after a supervisor write, and reset clears every output. The bench scenarios cover the rest, since each needs a history of writes: bank isolation across every register of every bank, the choice of bank on both paths, clamping of an out-of-range index to bank 0, which write wins when both fire together, the old value returned on a read during a write, and a control register that keeps its value after a refused user write.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SET_W  = 6;  // bank index width, up to 64 banks
  localparam int REG_AW = 5;  // 32 registers per bank
  localparam int CR_AW  = 5;  // up to 32 control registers
  localparam int NRP    = 3;  // read ports: A, B, cross

  // An index beyond the last built bank falls back to bank 0.
  function automatic logic [SET_W-1:0] clamp_set(input logic [SET_W-1:0] s,
                                                 input int unsigned lim);
    return (32'(s) > lim) ? '0 : s;
  endfunction
endpackage

// File: rtl/rf_ram.sv
module rf_ram #(
  parameter int DW = 32,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first: the registered read sees the contents before this edge's write.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int DW     = 32,
  parameter int BANK_W = 2,
  parameter int RAW    = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [BANK_W-1:0]     wr_bank,
  input  logic [RAW-1:0]        wr_reg,
  input  logic [DW-1:0]         wr_data,
  input  logic                  xw_en,
  input  logic [BANK_W-1:0]     xw_bank,
  input  logic [RAW-1:0]        xw_reg,
  input  logic [DW-1:0]         xw_data,
  output logic                  m_we,
  output logic [BANK_W+RAW-1:0] m_addr,
  output logic [DW-1:0]         m_data,
  output logic [2**(BANK_W+RAW)-1:0] vld
);
  logic           sel_en;
  logic [RAW-1:0] sel_reg;

  // The normal write owns the port; the cross write only takes it when idle.
  always_comb begin
    if (wr_en) begin
      sel_en  = 1'b1;
      sel_reg = wr_reg;
      m_addr  = {wr_bank, wr_reg};
      m_data  = wr_data;
    end else begin
      sel_en  = xw_en;
      sel_reg = xw_reg;
      m_addr  = {xw_bank, xw_reg};
      m_data  = xw_data;
    end
    m_we = sel_en && (sel_reg != '0);
  end

  // Written-since-reset flags stand in for clearing the RAM contents.
  always_ff @(posedge clk) begin
    if (rst)       vld <= '0;
    else if (m_we) vld[m_addr] <= 1'b1;
  end
endmodule

// File: rtl/rf_ctrl_bank.sv
module rf_ctrl_bank #(
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int NUM_CTRL = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          super_mode,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          fault
);
  logic [DW-1:0] cregs [NUM_CTRL];
  logic [DW-1:0] rd_mux;
  logic          wr_ok;

  assign wr_ok = wr_en && super_mode;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == AW'(i)) rd_mux = cregs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CTRL; i++) cregs[i] <= '0;
      rd_data <= '0;
      fault   <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (wr_ok && wr_addr == AW'(i)) cregs[i] <= wr_data;
      rd_data <= rd_mux;
      fault   <= wr_en && !super_mode;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int XLEN       = 32,
  parameter int NUM_SHADOW = 3,
  parameter int NUM_CTRL   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [rf_pkg::SET_W-1:0] cur_set,
  input  logic [rf_pkg::SET_W-1:0] prev_set,
  input  logic                     super_mode,
  input  logic [4:0]               ra_addr,
  output logic [XLEN-1:0]          ra_data,
  input  logic [4:0]               rb_addr,
  output logic [XLEN-1:0]          rb_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_addr,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [4:0]               xr_addr,
  output logic [XLEN-1:0]          xr_data,
  input  logic                     xw_en,
  input  logic [4:0]               xw_addr,
  input  logic [XLEN-1:0]          xw_data,
  input  logic [4:0]               cr_rd_addr,
  output logic [XLEN-1:0]          cr_rd_data,
  input  logic                     cr_wr_en,
  input  logic [4:0]               cr_wr_addr,
  input  logic [XLEN-1:0]          cr_wr_data,
  output logic                     priv_fault
);
  import rf_pkg::*;

  localparam int NBANK  = NUM_SHADOW + 1;
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int AW     = BANK_W + REG_AW;
  localparam int DEPTH  = 2 ** AW;

  logic [BANK_W-1:0] cur_bank, prev_bank;
  logic              m_we;
  logic [AW-1:0]     m_addr;
  logic [XLEN-1:0]   m_data;
  logic [DEPTH-1:0]  vld;
  logic [AW-1:0]     rd_addr [NRP];
  logic [XLEN-1:0]   ram_q   [NRP];
  logic [XLEN-1:0]   port_q  [NRP];
  logic [NRP-1:0]    vld_q;

  assign cur_bank  = BANK_W'(clamp_set(cur_set,  NUM_SHADOW));
  assign prev_bank = BANK_W'(clamp_set(prev_set, NUM_SHADOW));

  assign rd_addr[0] = {cur_bank,  ra_addr};
  assign rd_addr[1] = {cur_bank,  rb_addr};
  assign rd_addr[2] = {prev_bank, xr_addr};

  rf_write_arb #(.DW(XLEN), .BANK_W(BANK_W), .RAW(REG_AW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_bank (cur_bank),
    .wr_reg  (wr_addr),
    .wr_data (wr_data),
    .xw_en   (xw_en),
    .xw_bank (prev_bank),
    .xw_reg  (xw_addr),
    .xw_data (xw_data),
    .m_we    (m_we),
    .m_addr  (m_addr),
    .m_data  (m_data),
    .vld     (vld)
  );

  // One RAM copy per read port, all fed by the single merged write port.
  for (genvar p = 0; p < NRP; p++) begin : g_port
    rf_ram #(.DW(XLEN), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (m_we),
      .waddr (m_addr),
      .wdata (m_data),
      .raddr (rd_addr[p]),
      .rdata (ram_q[p])
    );

    always_ff @(posedge clk) begin
      if (rst) vld_q[p] <= 1'b0;
      else     vld_q[p] <= vld[rd_addr[p]];
    end

    assign port_q[p] = ram_q[p] & {XLEN{vld_q[p]}};
  end

  assign ra_data = port_q[0];
  assign rb_data = port_q[1];
  assign xr_data = port_q[2];

  rf_ctrl_bank #(.DW(XLEN), .AW(CR_AW), .NUM_CTRL(NUM_CTRL)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .super_mode (super_mode),
    .rd_addr    (cr_rd_addr),
    .rd_data    (cr_rd_data),
    .wr_en      (cr_wr_en),
    .wr_addr    (cr_wr_addr),
    .wr_data    (cr_wr_data),
    .fault      (priv_fault)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            super_mode,
  input logic [4:0]      ra_addr,
  input logic [XLEN-1:0] ra_data,
  input logic [4:0]      rb_addr,
  input logic [XLEN-1:0] rb_data,
  input logic [4:0]      xr_addr,
  input logic [XLEN-1:0] xr_data,
  input logic [XLEN-1:0] cr_rd_data,
  input logic            cr_wr_en,
  input logic            priv_fault
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ra_data == '0 && rb_data == '0 && xr_data == '0 &&
             cr_rd_data == '0 && !priv_fault)); // R11

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
    ra_addr == 5'd0 |=> ra_data == '0); // R4

  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
    rb_addr == 5'd0 |=> rb_data == '0); // R4

  AST_ZERO_REG_X: assert property (@(posedge clk) disable iff (rst)
    xr_addr == 5'd0 |=> xr_data == '0); // R4

  AST_USER_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (cr_wr_en && !super_mode) |=> priv_fault); // R10

  AST_SUPER_WRITE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (cr_wr_en && super_mode) |=> !priv_fault); // R9
endmodule

bind banked_regfile banked_regfile_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int NB = 4;   // banks with default NUM_SHADOW = 3
  localparam int NC = 16;  // default NUM_CTRL

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cur_set = '0, prev_set = '0;
  logic        super_mode = 1'b1;
  logic [4:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0, xr_addr = '0, xw_addr = '0;
  logic [31:0] ra_data, rb_data, xr_data, cr_rd_data;
  logic        wr_en = 1'b0, xw_en = 1'b0, cr_wr_en = 1'b0, priv_fault;
  logic [31:0] wr_data = '0, xw_data = '0, cr_wr_data = '0;
  logic [4:0]  cr_rd_addr = '0, cr_wr_addr = '0;

  int errors = 0;
  int checks = 0;
  logic [31:0] mdl [NB][32];
  logic [31:0] cmdl [NC];

  always #10 clk = ~clk;  // 50 MHz

  banked_regfile u_banked_regfile (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int b, input int r, input int salt);
    return 32'h1000_0000 * 32'(b + 1) + 32'h0001_0101 * 32'(r) + 32'(salt);
  endfunction

  task automatic gwrite(input int set, input int r, input logic [31:0] d);
    cur_set = 6'(set); wr_addr = 5'(r); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 32; r++) mdl[b][r] = '0;
    for (int i = 0; i < NC; i++) cmdl[i] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R11: everything reads zero after reset
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < 32; r++) begin
        cur_set = 6'(b); prev_set = 6'(b);
        ra_addr = 5'(r); rb_addr = 5'(31 - r); xr_addr = 5'(r);
        @(negedge clk);
        chk("R11 ra", ra_data, 32'h0);
        chk("R11 xr", xr_data, 32'h0);
      end
    end
    for (int i = 0; i < 32; i++) begin
      cr_rd_addr = 5'(i); @(negedge clk);
      chk("R11 ctrl", cr_rd_data, 32'h0);
    end
    chk("R11 fault", {31'h0, priv_fault}, 32'h0);

    // R1/R3/R4: fill every bank, including attempted writes to register 0
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 32; r++) begin
        gwrite(b, r, pat(b, r, 0));
        if (r != 0) mdl[b][r] = pat(b, r, 0);
      end

    // R1/R2/R4: sweep both read ports over every bank
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 32; r++) begin
        cur_set = 6'(b); ra_addr = 5'(r); rb_addr = 5'(31 - r);
        @(negedge clk);
        chk("R2 ra", ra_data, mdl[b][r]);
        chk("R2 rb", rb_data, mdl[b][31 - r]);
      end

    // R7: read of the register being written returns the old value
    cur_set = 6'd1; ra_addr = 5'd7;
    wr_addr = 5'd7; wr_data = 32'hCAFE_0007; wr_en = 1'b1;
    @(negedge clk);
    chk("R7 old value", ra_data, mdl[1][7]);
    wr_en = 1'b0; mdl[1][7] = 32'hCAFE_0007;
    @(negedge clk);
    chk("R7 new value", ra_data, mdl[1][7]);

    // R5: cross reads from every bank while bank 0 is active
    cur_set = 6'd0;
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 32; r++) begin
        prev_set = 6'(b); xr_addr = 5'(r);
        @(negedge clk);
        chk("R5 xr", xr_data, mdl[b][r]);
      end

    // R6: cross write lands in the previous bank only
    cur_set = 6'd0; prev_set = 6'd2;
    xw_addr = 5'd9; xw_data = 32'hBEEF_0009; xw_en = 1'b1;
    @(negedge clk);
    xw_en = 1'b0; mdl[2][9] = 32'hBEEF_0009;
    xr_addr = 5'd9; ra_addr = 5'd9;
    @(negedge clk);
    chk("R6 xr target", xr_data, mdl[2][9]);
    chk("R6 active untouched", ra_data, mdl[0][9]);

    // R4: cross write to register 0 discarded
    xw_addr = 5'd0; xw_data = 32'hFFFF_FFFF; xw_en = 1'b1;
    @(negedge clk);
    xw_en = 1'b0; xr_addr = 5'd0;
    @(negedge clk);
    chk("R4 cross r0", xr_data, 32'h0);

    // R6: simultaneous writes, normal one wins
    cur_set = 6'd0; prev_set = 6'd2;
    wr_addr = 5'd10; wr_data = 32'h1111_000A; wr_en = 1'b1;
    xw_addr = 5'd10; xw_data = 32'h2222_000A; xw_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; xw_en = 1'b0; mdl[0][10] = 32'h1111_000A;
    ra_addr = 5'd10; xr_addr = 5'd10;
    @(negedge clk);
    chk("R6 normal wins", ra_data, mdl[0][10]);
    chk("R6 cross dropped", xr_data, mdl[2][10]);

    // R8: out-of-range indices map to bank 0
    foreach (mdl[0][r]) begin
      cur_set = 6'(4 + r); prev_set = 6'(63 - r);
      ra_addr = 5'(r); xr_addr = 5'(r);
      @(negedge clk);
      chk("R8 cur clamp", ra_data, mdl[0][r]);
      chk("R8 prev clamp", xr_data, mdl[0][r]);
    end
    gwrite(50, 3, 32'h5050_0003); mdl[0][3] = 32'h5050_0003;
    cur_set = 6'd0; ra_addr = 5'd3;
    @(negedge clk);
    chk("R8 write clamp", ra_data, mdl[0][3]);
    cur_set = 6'd3;
    @(negedge clk);
    chk("R8 other bank intact", ra_data, mdl[3][3]);

    // R9: supervisor writes over the full address space
    super_mode = 1'b1;
    for (int i = 0; i < 32; i++) begin
      cr_wr_addr = 5'(i); cr_wr_data = 32'hC000_0000 + 32'(i); cr_wr_en = 1'b1;
      @(negedge clk);
      cr_wr_en = 1'b0;
      chk("R9 no fault", {31'h0, priv_fault}, 32'h0);
      if (i < NC) cmdl[i] = 32'hC000_0000 + 32'(i);
    end
    for (int i = 0; i < 32; i++) begin
      cr_rd_addr = 5'(i); @(negedge clk);
      chk("R9 ctrl read", cr_rd_data, (i < NC) ? cmdl[i] : 32'h0);
    end

    // R10: user-mode write suppressed and flagged for one cycle
    super_mode = 1'b0;
    cr_wr_addr = 5'd3; cr_wr_data = 32'hDEAD_DEAD; cr_wr_en = 1'b1;
    @(negedge clk);
    cr_wr_en = 1'b0;
    chk("R10 fault set", {31'h0, priv_fault}, 32'h1);
    cr_rd_addr = 5'd3;
    @(negedge clk);
    chk("R10 fault clears", {31'h0, priv_fault}, 32'h0);
    chk("R10 value kept", cr_rd_data, cmdl[3]);
    super_mode = 1'b1;

    // R11: reset in mid-run clears written state
    do_reset();
    cur_set = 6'd1; ra_addr = 5'd7; prev_set = 6'd2; xr_addr = 5'd9; cr_rd_addr = 5'd3;
    @(negedge clk);
    chk("R11 gpr cleared", ra_data, 32'h0);
    chk("R11 cross cleared", xr_data, 32'h0);
    chk("R11 ctrl cleared", cr_rd_data, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule